// File: doc/BRIEF.md
# Prescaled Up-Counting Event Timer

This block is one timer channel behind a small 32-bit word-register port. Software sets a terminal value, a clock divisor and a run mode, then enables the channel. A 28-bit counter advances by one on every prescaled tick. Each tick is derived from the bus clock by a 16-bit divisor. When the counter is about to reach the terminal value, or would roll over past all ones, it returns to zero and records a sticky event flag. That flag can drive a level interrupt line.

Two run modes exist. In periodic mode the counter keeps cycling, which makes the channel a steady tick source or a free-running time base. In one-shot mode the channel disables itself after the first event, which suits programmable single delays. A terminal value of zero turns off matching, so the channel becomes a plain wrapping counter.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset every register reads 0 and `irq` is low.
- R2: Word offsets are 0x0 terminal value (bits 27:0), 0x4 live count (bits 27:0), 0x8 control (bit 28 enable, bit 24 mode with 1 = periodic and 0 = one-shot, bits 15:0 divisor) and 0xC interrupt (bit 20 enable, bit 16 pending). Undefined bits read 0. `bus_rdata` is registered: it shows the addressed register as it stood before the clock edge that accepts the read, and it holds its value when no read is made.
- R3: While enabled, the count advances once every max(divisor,1) clocks. The first advance happens D edges after the edge that accepts the enabling control write.
- R4: When the next count value would equal a non-zero terminal value N, the count becomes 0 instead and the pending flag is set, so an event occurs every N ticks.
- R5: Advancing from all ones (0x0FFFFFFF at the default width) also yields 0 and sets pending. A terminal value of 0 disables matching, so only this wrap raises an event.
- R6: In periodic mode the channel keeps counting after an event. In one-shot mode it stops with count 0, and the enable bit then reads 0.
- R7: A control write with the enable bit set restarts the prescaler and the count from 0. A control write with the enable bit clear stops the channel, and the count holds its value.
- R8: The pending flag is sticky. Writing 1 to bit 16 of the interrupt register clears it, and writing 0 there leaves it unchanged. An event in the same cycle as a clear wins.
- R9: `irq` equals pending AND interrupt enable, registered, so it lags both by one clock. A cleared enable masks it while pending still reads 1.
- R10: Writes to the live-count offset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, bits 3:2 pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, registered |

## Verification
A wrong prescaler phase or counter value first appears in the live-count register: one read after a known number of clocks shows the error as an exact mismatch, within a single tick period. A faulty event comparison or stop decision shows up one period later as a pending flag, an enable bit or an `irq` level that disagrees with the tick count computed from the divisor and terminal value. A broken clear or mask shows up on `irq` one clock after the offending write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned WORD_END     = 0;
  localparam int unsigned WORD_CNT     = 1;
  localparam int unsigned WORD_CTL     = 2;
  localparam int unsigned WORD_IRQ     = 3;
  localparam int unsigned CTL_EN_BIT   = 28;
  localparam int unsigned CTL_MODE_BIT = 24;
  localparam int unsigned IRQ_EN_BIT   = 20;
  localparam int unsigned IRQ_PEND_BIT = 16;

  typedef enum logic {
    MODE_ONESHOT  = 1'b0,
    MODE_PERIODIC = 1'b1
  } run_mode_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit_m1;

  assign limit_m1 = (divisor == '0) ? '0 : divisor - 1'b1;
  assign tick     = run && (cnt_q == limit_m1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R3: the phase counter never passes the divisor limit
  assert_presc_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= limit_m1);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] end_val,
  output logic [CNT_W-1:0] count,
  output logic             evt
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] nxt;

  assign nxt   = count_q + 1'b1;
  assign evt   = tick && ((count_q == '1) || ((end_val != '0) && (nxt == end_val)));
  assign count = count_q;

  always_ff @(posedge clk) begin
    if (rst || restart) count_q <= '0;
    else if (tick)      count_q <= evt ? '0 : nxt;
  end

  // R4 / R5: an event always leaves the count at zero
  assert_evt_zero_R4: assert property (@(posedge clk) disable iff (rst)
    evt |=> (count == '0));
  // R3: without a tick or restart the count holds
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart) |=> $stable(count));
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int unsigned CNT_W  = 28,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_sel,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [tmr_pkg::DATA_W-1:0] bus_wdata,
  output logic [tmr_pkg::DATA_W-1:0] bus_rdata,
  output logic                      irq
);
  import tmr_pkg::*;

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              wr_end, wr_ctl, wr_irq, rd_any;
  logic [CNT_W-1:0]  end_q;
  logic [DIV_W-1:0]  div_q;
  run_mode_e         mode_q;
  logic              run_q, ie_q, pend_q, irq_q;
  logic              restart, tick, evt;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign word    = bus_addr[ADDR_W-1:2];
  assign wr_end  = bus_sel && bus_we && (word == WORD_W'(WORD_END));
  assign wr_ctl  = bus_sel && bus_we && (word == WORD_W'(WORD_CTL));
  assign wr_irq  = bus_sel && bus_we && (word == WORD_W'(WORD_IRQ));
  assign rd_any  = bus_sel && !bus_we;
  assign restart = wr_ctl && bus_wdata[CTL_EN_BIT];

  tmr_prescale #(.DIV_W(DIV_W)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q && !wr_ctl),
    .divisor (div_q),
    .tick    (tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (tick),
    .end_val (end_q),
    .count   (count),
    .evt     (evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      end_q  <= '0;
      div_q  <= '0;
      mode_q <= MODE_ONESHOT;
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_end) end_q <= bus_wdata[CNT_W-1:0];
      if (wr_ctl) begin
        run_q  <= bus_wdata[CTL_EN_BIT];
        mode_q <= run_mode_e'(bus_wdata[CTL_MODE_BIT]);
        div_q  <= bus_wdata[DIV_W-1:0];
      end else if (evt && mode_q == MODE_ONESHOT) begin
        run_q <= 1'b0;
      end
      if (wr_irq) ie_q <= bus_wdata[IRQ_EN_BIT];
      if (evt)                                pend_q <= 1'b1;
      else if (wr_irq && bus_wdata[IRQ_PEND_BIT]) pend_q <= 1'b0;
      irq_q <= pend_q && ie_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (word)
      WORD_W'(WORD_END): rd_mux[CNT_W-1:0] = end_q;
      WORD_W'(WORD_CNT): rd_mux[CNT_W-1:0] = count;
      WORD_W'(WORD_CTL): begin
        rd_mux[CTL_EN_BIT]   = run_q;
        rd_mux[CTL_MODE_BIT] = mode_q;
        rd_mux[DIV_W-1:0]    = div_q;
      end
      default: begin
        rd_mux[IRQ_EN_BIT]   = ie_q;
        rd_mux[IRQ_PEND_BIT] = pend_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_any) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  // R6: a one-shot channel drops its enable after the event
  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (evt && mode_q == MODE_ONESHOT && !wr_ctl) |=> !run_q);
  // R8: pending survives anything but a clear write
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !(wr_irq && bus_wdata[IRQ_PEND_BIT])) |=> pend_q);
  // R9: the interrupt line only follows an enabled pending flag
  assert_irq_src_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(pend_q && ie_q));
  // R2: read data changes only on a read
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_any |=> $stable(bus_rdata));
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
  localparam int SMALL_W = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_b, rdata_s;
  logic        irq_b, irq_s;
  logic [31:0] rd_b, rd_s;
  int          checks = 0;
  int          failures = 0;

  always #2 clk = ~clk;

  tick_timer i_tick_timer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .irq(irq_b));

  tick_timer #(.CNT_W(SMALL_W)) i_small (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_s), .irq(irq_s));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 1'b0;
    rd_b = rdata_b; rd_s = rdata_s;
  endtask

  task automatic start(input int n, input int d, input bit per);
    wr(4'h8, 32'h0);
    wr(4'h0, n);
    wr(4'hC, 32'h0011_0000);
    wr(4'h8, (32'h1 << 28) | (32'(per) << 24) | 32'(d));
  endtask

  function automatic int ticks(input int w, input int d);
    return w / ((d == 0) ? 1 : d);
  endfunction
  function automatic int eff_n(input int n, input int cw);
    return (n == 0) ? (1 << cw) : n;
  endfunction
  function automatic int exp_cnt(input int t, input int n, input bit per, input int cw);
    if (per) return t % eff_n(n, cw);
    return (t >= eff_n(n, cw)) ? 0 : t;
  endfunction
  function automatic bit exp_pend(input int t, input int n, input int cw);
    return t >= eff_n(n, cw);
  endfunction

  initial begin
    repeat (250000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4));
      chk("R1 reg", rd_b, 32'h0);
    end
    chk("R1 irq", {31'b0, irq_b}, 32'h0);

    // R2 layout and undefined bits
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0); chk("R2 end", rd_b, 32'h0FFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFF); rd(4'h8); chk("R2 ctl", rd_b, 32'h1100_FFFF);
    wr(4'hC, 32'hFFFF_FFFF); rd(4'hC); chk("R2 irqreg", rd_b, 32'h0010_0000);

    // R3 prescaler phase
    start(0, 3, 1'b1); repeat (10) @(posedge clk); rd(4'h4);
    chk("R3 div3", rd_b, 32'd3);
    start(0, 0, 1'b1); repeat (5) @(posedge clk); rd(4'h4);
    chk("R3 div0", rd_b, 32'd5);

    // R7 stop holds, R10 count write ignored
    start(0, 1, 1'b1); repeat (20) @(posedge clk);
    wr(4'h8, 32'h0); rd(4'h4); chk("R7 hold", rd_b, 32'd20);
    wr(4'h4, 32'h0000_0123); rd(4'h4); chk("R10 ignore", rd_b, 32'd20);
    // R7 restart
    wr(4'h8, 32'h1100_0001); rd(4'h4); chk("R7 restart", rd_b, 32'd0);

    // R5 zero terminal: no match, then wrap on the narrow instance
    start(0, 1, 1'b1); repeat (99) @(posedge clk);
    rd(4'h4); chk("R5 nomatch cnt", rd_b, 32'd99);
    rd(4'hC); chk("R5 nomatch pend", rd_b, 32'h0010_0000);
    start(0, 1, 1'b1); repeat (63) @(posedge clk);
    rd(4'h4); chk("R5 top", rd_s, 32'd63);
    rd(4'hC); chk("R5 wrap pend", rd_s, 32'h0011_0000);
    rd(4'h4); chk("R5 wrap cnt", rd_s, 32'd1);

    // R8 / R9 sticky, mask, clear
    start(3, 1, 1'b1); repeat (10) @(posedge clk);
    wr(4'h8, 32'h0);
    wr(4'hC, 32'h0010_0000); rd(4'hC);
    chk("R8 zero write", rd_b, 32'h0011_0000);
    chk("R9 irq on", {31'b0, irq_b}, 32'h1);
    wr(4'hC, 32'h0); @(posedge clk); #1;
    chk("R9 masked", {31'b0, irq_b}, 32'h0);
    rd(4'hC); chk("R9 pend kept", rd_b, 32'h0001_0000);
    wr(4'hC, 32'h0001_0000); rd(4'hC);
    chk("R8 clear", rd_b, 32'h0);

    // randomized runs: R4, R6, R8, R9
    for (int i = 0; i < 25; i++) begin
      int d = $urandom_range(0, 4);
      int n = $urandom_range(1, 12);
      bit per = 1'($urandom_range(0, 1));
      int w = $urandom_range(0, 60);
      bit run1;
      bit p2;
      start(n, d, per);
      repeat (w) @(posedge clk);
      rd(4'h4);
      chk("R4 count", rd_b, 32'(exp_cnt(ticks(w, d), n, per, 28)));
      rd(4'h8);
      run1 = per ? 1'b1 : !exp_pend(ticks(w + 1, d), n, 28);
      chk("R6 ctl", rd_b, (32'(run1) << 28) | (32'(per) << 24) | 32'(d));
      rd(4'hC);
      p2 = exp_pend(ticks(w + 2, d), n, 28);
      chk("R8 pend", rd_b, 32'h0010_0000 | (32'(p2) << 16));
      chk("R9 irq", {31'b0, irq_b}, {31'b0, p2});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule